// File: doc/BRIEF.md
# Video Memory Address and Data Port

This block sits between a CPU register window and the video memory of a tile-based display controller. It holds the scroll and address state the renderer consumes: a 15-bit staging address, a 15-bit live address, a 3-bit fine horizontal offset, and a single toggle that marks the first or second write of a two-byte sequence. CPU writes to the control, scroll and address registers scatter value bits into the staging address. A second address write commits the staging address into the live address.

CPU accesses to the data register move bytes to and from video memory at the live address. The live address then steps by 1 or by 32. Reads are delayed by one access through a one-byte buffer. The buffer is refilled from a memory with one cycle of read latency. Back-to-back reads are served by forwarding the returning byte.

When the live address falls in the palette window and rendering is inactive, data accesses go to a 32-entry palette held inside the block. Palette reads take their top two bits from the shared I/O latch. That latch records the last byte written to any register, and it is what reads of the write-only registers return.

Top module: `vid_addr_port`

## Requirements
- R1: After reset the staging address, live address, fine offset, toggle, I/O latch and read buffer are all zero, and neither memory strobe is active.
- R2: A control write (select 0) copies value bits 1..0 into staging bits 11..10, and value bit 2 chooses the data step: 32 when set, 1 when clear.
- R3: A scroll write (select 5) with the toggle clear loads staging bits 4..0 from value bits 7..3 and the fine offset from value bits 2..0.
- R4: A scroll write with the toggle set loads staging bits 9..8 from value bits 7..6, bits 7..5 from value bits 5..3, and bits 14..12 from value bits 2..0, leaving the other staging bits unchanged.
- R5: An address write (select 6) with the toggle clear loads staging bits 13..8 from value bits 5..0 and clears staging bit 14.
- R6: Every scroll or address write inverts the toggle, and both registers share it, so a scroll write followed by an address write makes the address write act as the second write.
- R7: An address write with the toggle set replaces staging bits 7..0 with the value and copies the resulting staging address into the live address.
- R8: A data read (select 7) outside the palette path returns the buffered byte in the same cycle. It pulses the memory read strobe with the address equal to live bits 13..0, and the buffer takes the returned byte one cycle later.
- R9: On consecutive-cycle data reads, each read returns the byte fetched by the read before it.
- R10: With live bits 13..0 at or above 0x3F00 and rendering inactive, a data read returns the palette entry at live bits 4..0 with its bits 7..6 replaced by I/O latch bits 7..6. The memory read strobe still fires and the buffer is still refilled.
- R11: A data write goes to the palette entry at live bits 4..0, with no memory write strobe, when in the palette window with rendering inactive; otherwise it pulses the memory write strobe with the value at live bits 13..0.
- R12: After every data read or write the live address advances by the selected step, modulo 2^15; no other access changes it except R7.
- R13: Reads of any select other than 7 return the I/O latch; every register write loads the latch with the value, and every data read loads it with the returned byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_sel | input | 3 | Register select |
| cpu_wr | input | 1 | Register write strobe, one cycle per write |
| cpu_rd | input | 1 | Register read strobe, one cycle per read |
| cpu_wdata | input | 8 | Write value |
| cpu_rdata | output | 8 | Read value, valid in the cycle of the read strobe |
| render_active | input | 1 | High while the renderer owns video memory |
| vm_addr | output | 14 | Video memory address |
| vm_rd | output | 1 | Video memory read strobe |
| vm_wr | output | 1 | Video memory write strobe |
| vm_wdata | output | 8 | Video memory write data |
| vm_rdata | input | 8 | Video memory read data, one cycle after the strobe |
| tmp_addr | output | 15 | Staging address |
| cur_addr | output | 15 | Live address |
| fine_x | output | 3 | Fine horizontal offset |
| wr_toggle | output | 1 | First/second write toggle |

## Verification
The hardest case to reach is a data read issued in the very cycle that the previous read's fill byte is still in flight from memory. In that cycle the buffer register is stale, and only the forwarding path gives the right answer. The stimulus first places the live address with a pair of address writes. It then holds the read strobe high for three consecutive cycles and compares each returned byte against the memory pattern at the address of the read before it. Palette reads are reached the same way, after a mask write has preloaded the latch's top bits with a known pattern.

// File: rtl/vap_pkg.sv
// Shared constants and types for the video memory address and data port.
// Assumes a 3-bit register select and byte-wide CPU data.
package vap_pkg;
    localparam int DATA_W = 8;
    localparam int VM_AW  = 14;
    localparam int LOOP_W = VM_AW + 1;
    localparam int FX_W   = 3;
    localparam int SEL_W  = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_CTRL = 3'd0,
        SEL_MASK = 3'd1,
        SEL_STAT = 3'd2,
        SEL_OBJA = 3'd3,
        SEL_OBJD = 3'd4,
        SEL_SCRL = 3'd5,
        SEL_ADDR = 3'd6,
        SEL_DATA = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic ctrl_wr;
        logic scrl_wr;
        logic addr_wr;
        logic data_wr;
        logic data_rd;
        logic any_wr;
    } access_s;
endpackage

// File: rtl/vap_decode.sv
// Turns the CPU select and strobes into one access kind per cycle.
// Assumes at most one of cpu_wr and cpu_rd is high; a write wins if both are.
module vap_decode
    import vap_pkg::*;
(
    input  logic [SEL_W-1:0] cpu_sel,
    input  logic             cpu_wr,
    input  logic             cpu_rd,
    output access_s          acc
);
    // Decode the register touched by this cycle's strobe.
    always_comb begin
        acc         = '0;
        acc.any_wr  = cpu_wr;
        acc.ctrl_wr = cpu_wr && (cpu_sel == SEL_CTRL);
        acc.scrl_wr = cpu_wr && (cpu_sel == SEL_SCRL);
        acc.addr_wr = cpu_wr && (cpu_sel == SEL_ADDR);
        acc.data_wr = cpu_wr && (cpu_sel == SEL_DATA);
        acc.data_rd = cpu_rd && !cpu_wr && (cpu_sel == SEL_DATA);
    end
endmodule

// File: rtl/vap_addr_regs.sv
// Staging address, live address, fine offset, write toggle and step select.
// Assumes the access strobes are mutually exclusive in a cycle.
module vap_addr_regs
    import vap_pkg::*;
#(
    parameter int ROW_STEP = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              scrl_wr,
    input  logic              addr_wr,
    input  logic              data_acc,
    input  logic [DATA_W-1:0] wdata,
    output logic [LOOP_W-1:0] t_q,
    output logic [LOOP_W-1:0] v_q,
    output logic [FX_W-1:0]   x_q,
    output logic              w_q
);
    localparam logic [LOOP_W-1:0] ROW_INC  = LOOP_W'(ROW_STEP);
    localparam logic [LOOP_W-1:0] UNIT_INC = LOOP_W'(1);

    logic              row_mode;
    logic [LOOP_W-1:0] step;

    // Pick the live-address step from the control bit.
    always_comb step = row_mode ? ROW_INC : UNIT_INC;

    // Update address state on register writes and data accesses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q      <= '0;
            v_q      <= '0;
            x_q      <= '0;
            w_q      <= 1'b0;
            row_mode <= 1'b0;
        end else begin
            if (ctrl_wr) begin
                t_q[11:10] <= wdata[1:0];
                row_mode   <= wdata[2];
            end
            if (scrl_wr) begin
                if (!w_q) begin
                    t_q[4:0] <= wdata[7:3];
                    x_q      <= wdata[2:0];
                end else begin
                    t_q[9:8]   <= wdata[7:6];
                    t_q[7:5]   <= wdata[5:3];
                    t_q[14:12] <= wdata[2:0];
                end
                w_q <= ~w_q;
            end
            if (addr_wr) begin
                if (!w_q) begin
                    t_q[13:8] <= wdata[5:0];
                    t_q[14]   <= 1'b0;
                end else begin
                    t_q[7:0] <= wdata;
                    v_q      <= {t_q[14:8], wdata};
                end
                w_q <= ~w_q;
            end
            if (data_acc) begin
                v_q <= v_q + step;
            end
        end
    end
endmodule

// File: rtl/vap_data_path.sv
// Read buffer with fill forwarding, I/O latch, palette store and memory strobes.
// Assumes video memory returns read data one cycle after vm_rd.
module vap_data_path
    import vap_pkg::*;
#(
    parameter int                PAL_ENTRIES = 32,
    parameter logic [VM_AW-1:0]  PAL_BASE    = 14'h3F00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              any_wr,
    input  logic              data_wr,
    input  logic              data_rd,
    input  logic              render_active,
    input  logic [DATA_W-1:0] wdata,
    input  logic [VM_AW-1:0]  v_lo,
    input  logic [DATA_W-1:0] vm_rdata,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic [VM_AW-1:0]  vm_addr,
    output logic              vm_rd,
    output logic              vm_wr,
    output logic [DATA_W-1:0] vm_wdata
);
    localparam int PAL_IW = $clog2(PAL_ENTRIES);

    logic              pal_zone;
    logic [PAL_IW-1:0] pal_idx;
    logic              fill_pend;
    logic [DATA_W-1:0] rd_buf;
    logic [DATA_W-1:0] buf_now;
    logic [DATA_W-1:0] io_latch;
    logic [DATA_W-1:0] data_val;
    logic [DATA_W-1:0] pal_q [PAL_ENTRIES];

    // Palette path applies in the window while the renderer is idle.
    always_comb begin
        pal_zone = (v_lo >= PAL_BASE) && !render_active;
        pal_idx  = v_lo[PAL_IW-1:0];
    end

    // Memory strobes follow the live address in the access cycle.
    always_comb begin
        vm_addr  = v_lo;
        vm_rd    = data_rd;
        vm_wr    = data_wr && !pal_zone;
        vm_wdata = wdata;
    end

    // Remember that a fill byte arrives in the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) fill_pend <= 1'b0;
        else        fill_pend <= data_rd;
    end

    // Capture the returning fill byte into the read buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)         rd_buf <= '0;
        else if (fill_pend) rd_buf <= vm_rdata;
    end

    // Forward an in-flight fill so consecutive reads stay ordered.
    always_comb buf_now = fill_pend ? vm_rdata : rd_buf;

    // Choose between buffered byte and palette entry for a data read.
    always_comb begin
        if (pal_zone) data_val = {io_latch[7:6], pal_q[pal_idx][5:0]};
        else          data_val = buf_now;
    end

    // Return data for the data register, the latch for all others.
    always_comb cpu_rdata = data_rd ? data_val : io_latch;

    // Load the shared I/O latch from writes and data reads.
    always_ff @(posedge clk) begin
        if (!rst_n)       io_latch <= '0;
        else if (any_wr)  io_latch <= wdata;
        else if (data_rd) io_latch <= data_val;
    end

    // One register per palette entry, each with its own write enable.
    for (genvar g = 0; g < PAL_ENTRIES; g++) begin : gen_pal
        logic [DATA_W-1:0] entry;

        // Store a CPU byte into this entry on a palette-path write.
        always_ff @(posedge clk) begin
            if (!rst_n) entry <= '0;
            else if (data_wr && pal_zone && (pal_idx == PAL_IW'(g))) entry <= wdata;
        end

        assign pal_q[g] = entry;
    end
endmodule

// File: rtl/vid_addr_port.sv
// Top of the video memory address and data port: decode, address state,
// and data path. Assumes one CPU access per cycle and a one-cycle memory.
module vid_addr_port
    import vap_pkg::*;
#(
    parameter int                PAL_ENTRIES = 32,
    parameter logic [VM_AW-1:0]  PAL_BASE    = 14'h3F00,
    parameter int                ROW_STEP    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  cpu_sel,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              render_active,
    output logic [VM_AW-1:0]  vm_addr,
    output logic              vm_rd,
    output logic              vm_wr,
    output logic [DATA_W-1:0] vm_wdata,
    input  logic [DATA_W-1:0] vm_rdata,
    output logic [LOOP_W-1:0] tmp_addr,
    output logic [LOOP_W-1:0] cur_addr,
    output logic [FX_W-1:0]   fine_x,
    output logic              wr_toggle
);
    access_s acc;

    vap_decode u_decode (
        .cpu_sel (cpu_sel),
        .cpu_wr  (cpu_wr),
        .cpu_rd  (cpu_rd),
        .acc     (acc)
    );

    vap_addr_regs #(
        .ROW_STEP (ROW_STEP)
    ) u_addr_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (acc.ctrl_wr),
        .scrl_wr  (acc.scrl_wr),
        .addr_wr  (acc.addr_wr),
        .data_acc (acc.data_wr || acc.data_rd),
        .wdata    (cpu_wdata),
        .t_q      (tmp_addr),
        .v_q      (cur_addr),
        .x_q      (fine_x),
        .w_q      (wr_toggle)
    );

    vap_data_path #(
        .PAL_ENTRIES (PAL_ENTRIES),
        .PAL_BASE    (PAL_BASE)
    ) u_data_path (
        .clk           (clk),
        .rst_n         (rst_n),
        .any_wr        (acc.any_wr),
        .data_wr       (acc.data_wr),
        .data_rd       (acc.data_rd),
        .render_active (render_active),
        .wdata         (cpu_wdata),
        .v_lo          (cur_addr[VM_AW-1:0]),
        .vm_rdata      (vm_rdata),
        .cpu_rdata     (cpu_rdata),
        .vm_addr       (vm_addr),
        .vm_rd         (vm_rd),
        .vm_wr         (vm_wr),
        .vm_wdata      (vm_wdata)
    );
endmodule

// File: rtl/vap_checker.sv
// Port-level properties of the video memory address and data port,
// bound to every instance of the top module.
module vap_checker
    import vap_pkg::*;
#(
    parameter logic [VM_AW-1:0] PAL_BASE = 14'h3F00,
    parameter int               ROW_STEP = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SEL_W-1:0]  cpu_sel,
    input logic              cpu_wr,
    input logic              cpu_rd,
    input logic [DATA_W-1:0] cpu_wdata,
    input logic [DATA_W-1:0] cpu_rdata,
    input logic              render_active,
    input logic [VM_AW-1:0]  vm_addr,
    input logic              vm_rd,
    input logic              vm_wr,
    input logic [DATA_W-1:0] vm_wdata,
    input logic [DATA_W-1:0] vm_rdata,
    input logic [LOOP_W-1:0] tmp_addr,
    input logic [LOOP_W-1:0] cur_addr,
    input logic [FX_W-1:0]   fine_x,
    input logic              wr_toggle
);
    localparam logic [LOOP_W-1:0] ROW_INC = LOOP_W'(ROW_STEP);

    logic data_acc;
    logic pal_sel;
    always_comb begin
        data_acc = (cpu_wr || cpu_rd) && (cpu_sel == 3'd7);
        pal_sel  = (cur_addr[VM_AW-1:0] >= PAL_BASE) && !render_active;
    end

    AST_CTRL_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_sel == 3'd0) |=> tmp_addr[11:10] == $past(cpu_wdata[1:0])); // R2

    AST_SCROLL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_sel == 3'd5 && !wr_toggle) |=>
        (fine_x == $past(cpu_wdata[2:0]) && tmp_addr[4:0] == $past(cpu_wdata[7:3]))); // R3

    AST_SCROLL_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_sel == 3'd5 && wr_toggle) |=>
        (tmp_addr[9:5] == $past(cpu_wdata[7:3]) && tmp_addr[14:12] == $past(cpu_wdata[2:0]))); // R4

    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && (cpu_sel == 3'd5 || cpu_sel == 3'd6)) |=> wr_toggle != $past(wr_toggle)); // R6

    AST_ADDR_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_sel == 3'd6 && wr_toggle) |=>
        cur_addr == {$past(tmp_addr[14:8]), $past(cpu_wdata)}); // R7

    AST_READ_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !cpu_wr && cpu_sel == 3'd7) |-> (vm_rd && vm_addr == cur_addr[VM_AW-1:0])); // R8

    AST_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(vm_rd) && cpu_rd && !cpu_wr && cpu_sel == 3'd7 && !pal_sel) |->
        cpu_rdata == vm_rdata); // R9

    AST_PAL_NO_VM: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_sel == 3'd7 && pal_sel) |-> !vm_wr); // R11

    AST_VM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_sel == 3'd7 && render_active) |->
        (vm_wr && vm_wdata == cpu_wdata && vm_addr == cur_addr[VM_AW-1:0])); // R11

    AST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        data_acc |=> ((cur_addr - $past(cur_addr)) == LOOP_W'(1) ||
                      (cur_addr - $past(cur_addr)) == ROW_INC)); // R12

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_acc && !(cpu_wr && cpu_sel == 3'd6 && wr_toggle)) |=> $stable(cur_addr)); // R12

    AST_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cpu_wr) && cpu_rd && !cpu_wr && cpu_sel != 3'd7) |->
        cpu_rdata == $past(cpu_wdata)); // R13
endmodule

bind vid_addr_port vap_checker #(
    .PAL_BASE (PAL_BASE),
    .ROW_STEP (ROW_STEP)
) i_vap_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cpu_sel       (cpu_sel),
    .cpu_wr        (cpu_wr),
    .cpu_rd        (cpu_rd),
    .cpu_wdata     (cpu_wdata),
    .cpu_rdata     (cpu_rdata),
    .render_active (render_active),
    .vm_addr       (vm_addr),
    .vm_rd         (vm_rd),
    .vm_wr         (vm_wr),
    .vm_wdata      (vm_wdata),
    .vm_rdata      (vm_rdata),
    .tmp_addr      (tmp_addr),
    .cur_addr      (cur_addr),
    .fine_x        (fine_x),
    .wr_toggle     (wr_toggle)
);

// File: tb/test_vid_addr_port.sv
// Directed bench for the video memory address and data port.
module test_vid_addr_port;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cpu_sel = '0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        render_active = 1'b0;
    logic [13:0] vm_addr;
    logic        vm_rd;
    logic        vm_wr;
    logic [7:0]  vm_wdata;
    logic [7:0]  vm_rdata;
    logic [14:0] tmp_addr;
    logic [14:0] cur_addr;
    logic [2:0]  fine_x;
    logic        wr_toggle;

    always #4 clk = ~clk;

    vid_addr_port i_vid_addr_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .cpu_sel       (cpu_sel),
        .cpu_wr        (cpu_wr),
        .cpu_rd        (cpu_rd),
        .cpu_wdata     (cpu_wdata),
        .cpu_rdata     (cpu_rdata),
        .render_active (render_active),
        .vm_addr       (vm_addr),
        .vm_rd         (vm_rd),
        .vm_wr         (vm_wr),
        .vm_wdata      (vm_wdata),
        .vm_rdata      (vm_rdata),
        .tmp_addr      (tmp_addr),
        .cur_addr      (cur_addr),
        .fine_x        (fine_x),
        .wr_toggle     (wr_toggle)
    );

    // Video memory model: content is a function of the address, one-cycle read.
    function automatic logic [7:0] pat(input logic [13:0] a);
        return a[7:0] ^ {a[13:8], 2'b11};
    endfunction

    logic [7:0] vm_q = '0;
    always_ff @(posedge clk) if (vm_rd) vm_q <= pat(vm_addr);
    assign vm_rdata = vm_q;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic        s_vm_rd, s_vm_wr;
    logic [13:0] s_vm_addr;
    logic [7:0]  s_vm_wdata;

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        cpu_sel = s; cpu_wdata = d; cpu_wr = 1'b1;
        #1;
        s_vm_wr = vm_wr; s_vm_addr = vm_addr; s_vm_wdata = vm_wdata;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [7:0] d);
        @(negedge clk);
        cpu_sel = s; cpu_rd = 1'b1;
        #1;
        d = cpu_rdata; s_vm_rd = vm_rd; s_vm_addr = vm_addr;
        @(negedge clk);
        cpu_rd = 1'b0;
    endtask

    task automatic set_live(input logic [13:0] a);
        wr(3'd6, {2'b00, a[13:8]});
        wr(3'd6, a[7:0]);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 staging", {1'b0, tmp_addr}, 16'h0000);
        check("R1 live", {1'b0, cur_addr}, 16'h0000);
        check("R1 fine", {13'b0, fine_x}, 16'h0000);
        check("R1 toggle", {15'b0, wr_toggle}, 16'h0000);
        check("R1 strobes", {14'b0, vm_rd, vm_wr}, 16'h0000);
        rd(3'd2, d);
        check("R1 latch", {8'h0, d}, 16'h0000);
    endtask

    task automatic t_ctrl();
        logic [7:0] d;
        wr(3'd0, 8'h03);
        check("R2 staging 11..10", {1'b0, tmp_addr}, 16'h0C00);
        rd(3'd0, d);
        check("R13 write-only read", {8'h0, d}, 16'h0003);
    endtask

    task automatic t_scroll();
        wr(3'd5, 8'h7D);
        check("R3 staging", {1'b0, tmp_addr}, 16'h0C0F);
        check("R3 fine", {13'b0, fine_x}, 16'h0005);
        check("R6 toggle set", {15'b0, wr_toggle}, 16'h0001);
        wr(3'd5, 8'h5E);
        check("R4 staging", {1'b0, tmp_addr}, 16'h6D6F);
        check("R4 fine kept", {13'b0, fine_x}, 16'h0005);
        check("R6 toggle clear", {15'b0, wr_toggle}, 16'h0000);
    endtask

    task automatic t_addr();
        wr(3'd6, 8'h7F);
        check("R5 staging", {1'b0, tmp_addr}, 16'h3F6F);
        check("R5 live untouched", {1'b0, cur_addr}, 16'h0000);
        wr(3'd6, 8'h05);
        check("R7 staging", {1'b0, tmp_addr}, 16'h3F05);
        check("R7 live", {1'b0, cur_addr}, 16'h3F05);
        wr(3'd5, 8'h00);
        wr(3'd6, 8'h12);
        check("R6 shared toggle staging", {1'b0, tmp_addr}, 16'h3F12);
        check("R6 shared toggle live", {1'b0, cur_addr}, 16'h3F12);
        check("R6 toggle back", {15'b0, wr_toggle}, 16'h0000);
    endtask

    task automatic t_read();
        logic [7:0] d;
        wr(3'd0, 8'h00);
        set_live(14'h0123);
        rd(3'd7, d);
        check("R8 first read buffer", {8'h0, d}, 16'h0000);
        check("R8 strobe", {15'b0, s_vm_rd}, 16'h0001);
        check("R8 address", {2'b0, s_vm_addr}, 16'h0123);
        check("R12 step 1", {1'b0, cur_addr}, 16'h0124);
        rd(3'd7, d);
        check("R8 buffered byte", {8'h0, d}, {8'h0, pat(14'h0123)});
        check("R8 next address", {2'b0, s_vm_addr}, 16'h0124);
        rd(3'd0, d);
        check("R13 latch from data read", {8'h0, d}, {8'h0, pat(14'h0123)});
    endtask

    task automatic t_burst();
        logic [7:0] a, b, c, d;
        set_live(14'h0200);
        @(negedge clk);
        cpu_sel = 3'd7; cpu_rd = 1'b1;
        #1 a = cpu_rdata;
        @(negedge clk);
        #1 b = cpu_rdata;
        @(negedge clk);
        #1 c = cpu_rdata;
        @(negedge clk);
        cpu_rd = 1'b0;
        check("R9 burst first", {8'h0, a}, {8'h0, pat(14'h0124)});
        check("R9 burst second", {8'h0, b}, {8'h0, pat(14'h0200)});
        check("R9 burst third", {8'h0, c}, {8'h0, pat(14'h0201)});
        check("R12 burst advance", {1'b0, cur_addr}, 16'h0203);
        rd(3'd7, d);
        check("R9 after burst", {8'h0, d}, {8'h0, pat(14'h0202)});
    endtask

    task automatic t_step();
        logic [7:0] d;
        wr(3'd0, 8'h04);
        set_live(14'h0040);
        rd(3'd7, d);
        check("R8 address row mode", {2'b0, s_vm_addr}, 16'h0040);
        check("R12 step 32 read", {1'b0, cur_addr}, 16'h0060);
        wr(3'd7, 8'h5A);
        check("R11 vm write strobe", {15'b0, s_vm_wr}, 16'h0001);
        check("R11 vm write address", {2'b0, s_vm_addr}, 16'h0060);
        check("R11 vm write data", {8'h0, s_vm_wdata}, 16'h005A);
        check("R12 step 32 write", {1'b0, cur_addr}, 16'h0080);
        wr(3'd0, 8'h00);
    endtask

    task automatic t_pal();
        logic [7:0] d;
        set_live(14'h3F03);
        wr(3'd7, 8'hC7);
        check("R11 palette write no strobe", {15'b0, s_vm_wr}, 16'h0000);
        check("R12 palette write step", {1'b0, cur_addr}, 16'h3F04);
        set_live(14'h3F03);
        wr(3'd1, 8'h80);
        rd(3'd1, d);
        check("R13 mask write loads latch", {8'h0, d}, 16'h0080);
        rd(3'd7, d);
        check("R10 palette read", {8'h0, d}, 16'h0087);
        check("R10 strobe still fires", {15'b0, s_vm_rd}, 16'h0001);
        check("R10 strobe address", {2'b0, s_vm_addr}, 16'h3F03);
        rd(3'd7, d);
        check("R10 palette unwritten entry", {8'h0, d}, 16'h0080);
        set_live(14'h0300);
        rd(3'd7, d);
        check("R10 buffer refilled", {8'h0, d}, {8'h0, pat(14'h3F04)});
    endtask

    task automatic t_render();
        logic [7:0] d;
        render_active = 1'b1;
        set_live(14'h3F08);
        wr(3'd7, 8'h11);
        check("R11 rendering write strobe", {15'b0, s_vm_wr}, 16'h0001);
        check("R11 rendering write address", {2'b0, s_vm_addr}, 16'h3F08);
        rd(3'd7, d);
        check("R10 rendering read uses buffer", {8'h0, d}, {8'h0, pat(14'h0300)});
        render_active = 1'b0;
        set_live(14'h3F08);
        rd(3'd7, d);
        check("R11 palette untouched while rendering", {8'h0, d}, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctrl();
        t_scroll();
        t_addr();
        t_read();
        t_burst();
        t_step();
        t_pal();
        t_render();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule